// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a local interrupt controller. Software programs a divide code, a start count and a timer table entry through a small register port. The table entry holds the interrupt vector, a mask bit and a periodic-mode bit. The timer then counts down once for every divided step of an external base tick enable. When the count runs out it records an expiry. An interrupt request carrying the entry's vector stays raised while expiries are outstanding, the controller is software-enabled and the entry is unmasked.

Each acknowledged request consumes one outstanding expiry. The block also holds five further table entries of the same controller, which only store a vector and a mask bit. It keeps them because turning the controller off must force every entry into the masked state together. Reads are combinational from the selected register. Writes take effect at the clock edge that samples them.

Top module: `intc_timer`

## Requirements
- R1: The divide register (select 3) stores bits 3:0 and reads them back. A count step happens every 2^(({b3,b1,b0}+1) mod 8) tick-enable pulses, so code 4'hB steps on every pulse and code 4'h0 steps on every second pulse.
- R2: A write to the start-count register (select 1) loads the current count with the written value and restarts the divider phase. A written zero leaves the timer stopped, and it then records no expiry.
- R3: The current count reads at select 2 and is 0 whenever the start count is 0. Writes to select 2 have no effect.
- R4: In one-shot mode the count falls by one per divided step. The step that takes it from 1 to 0 records one expiry. After that the count stays at 0 and records no further expiries.
- R5: With the periodic bit (timer entry bit 17) set, the step that would take the count from 1 to 0 instead loads the start count in that same step and records one expiry.
- R6: Every write to the start-count register clears the outstanding-expiry count.
- R7: irq_req is high exactly when the enable bit (select 0, bit 8) is set, the timer entry (select 8) has mask bit 16 clear and at least one expiry is outstanding. irq_vector carries entry bits 7:0.
- R8: irq_ack while irq_req is high removes one outstanding expiry. An expiry and an acknowledge in the same cycle cancel, and the count saturates at 2^PEND_W-1 (15 by default).
- R9: A write to select 0 with bit 8 clear sets the mask bit of all six table entries (selects 8 to 13) and clears the outstanding expiries.
- R10: A table-entry write made while the enable bit is clear is stored with its mask bit set. Only the timer entry keeps bit 17; the other entries read 0 there.
- R11: After reset, select 0 reads 0x000000FF, selects 1 to 3 read 0, every table entry reads 0x00010000 and irq_req is low.
- R12: Selects 4 to 7, 14 and 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base tick enable, one pulse per timer clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| irq_ack | input | 1 | Request taken; removes one outstanding expiry |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector from the timer entry |

## Verification
A register write shows at rd_data half a clock after the edge that samples it, with no further delay. A divided step, an expiry and an acknowledge change the count and irq_req at that same edge. A start at edge k therefore shows its new count at the sample after k, and a one-shot count of N at divide-by-1 raises irq_req at the sample after edge k+N. The bench drives every input at the falling edge and advances a reference model at each rising edge. It compares irq_req, irq_vector and the selected read word in the following half cycle, so every check lands in the cycle its result is due.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int REG_W      = 32;
    localparam int VEC_W      = 8;
    localparam int SEL_W      = 4;
    localparam int TBL_N      = 6;
    localparam int DIV_CODE_W = 4;
    localparam int RATIO_W    = 8;

    localparam logic [SEL_W-1:0] SEL_SPUR = 4'h0;
    localparam logic [SEL_W-1:0] SEL_INIT = 4'h1;
    localparam logic [SEL_W-1:0] SEL_CUR  = 4'h2;
    localparam logic [SEL_W-1:0] SEL_DIV  = 4'h3;
    localparam logic [SEL_W-1:0] SEL_TBL0 = 4'h8;

    localparam int SPUR_EN_BIT  = 8;
    localparam int TBL_MASK_BIT = 16;
    localparam int TBL_PER_BIT  = 17;

    localparam logic [VEC_W-1:0] SPUR_VEC_RST = 8'hFF;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vec;
    } tbl_entry_t;

    localparam tbl_entry_t TBL_RESET = '{periodic: 1'b0, masked: 1'b1, vec: '0};

    // sel = {code[3], code[1:0]}; shift wraps modulo 8
    function automatic logic [2:0] div_shift(input logic [2:0] sel);
        return sel + 3'd1;
    endfunction

    function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] sel);
        return RATIO_W'(1) << div_shift(sel);
    endfunction

    function automatic logic [REG_W-1:0] tbl_word(input tbl_entry_t e);
        logic [REG_W-1:0] w;
        w                = '0;
        w[VEC_W-1:0]     = e.vec;
        w[TBL_MASK_BIT]  = e.masked;
        w[TBL_PER_BIT]   = e.periodic;
        return w;
    endfunction

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [REG_W-1:0]         wr_data,
    output logic                     sw_en,
    output logic [VEC_W-1:0]         spur_vec,
    output tbl_entry_t [TBL_N-1:0]   tbl_q,
    output logic [DIV_CODE_W-1:0]    div_q,
    output logic [CNT_W-1:0]         init_q,
    output logic                     start,
    output logic                     sw_off
);

    logic spur_hit;
    logic init_hit;
    logic div_hit;

    assign spur_hit = wr_en && (wr_sel == SEL_SPUR);
    assign init_hit = wr_en && (wr_sel == SEL_INIT);
    assign div_hit  = wr_en && (wr_sel == SEL_DIV);
    assign start    = init_hit;
    assign sw_off   = spur_hit && !wr_data[SPUR_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_en    <= 1'b0;
            spur_vec <= SPUR_VEC_RST;
            div_q    <= '0;
            init_q   <= '0;
            for (int i = 0; i < TBL_N; i++) begin
                tbl_q[i] <= TBL_RESET;
            end
        end else begin
            if (spur_hit) begin
                sw_en    <= wr_data[SPUR_EN_BIT];
                spur_vec <= wr_data[VEC_W-1:0];
            end
            if (div_hit) begin
                div_q <= wr_data[DIV_CODE_W-1:0];
            end
            if (init_hit) begin
                init_q <= wr_data[CNT_W-1:0];
            end
            for (int i = 0; i < TBL_N; i++) begin
                if (sw_off) begin
                    tbl_q[i].masked <= 1'b1;
                end else if (wr_en && (wr_sel == SEL_TBL0 + SEL_W'(i))) begin
                    tbl_q[i].vec      <= wr_data[VEC_W-1:0];
                    tbl_q[i].masked   <= wr_data[TBL_MASK_BIT] | ~sw_en;
                    tbl_q[i].periodic <= (i == 0) ? wr_data[TBL_PER_BIT] : 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale
    import itmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       restart,
    input  logic [2:0] div_sel,
    output logic       div_tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    assign limit    = PRE_W'(div_ratio(div_sel)) - PRE_W'(1);
    // >= keeps a shrunk ratio from waiting for a wrap
    assign div_tick = tick_en && !restart && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (tick_en) begin
            phase_q <= div_tick ? '0 : phase_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             div_tick,
    output logic [CNT_W-1:0] cur_q,
    output logic             running_q,
    output logic             expire
);

    logic last_step;

    assign last_step = (cur_q == CNT_W'(1));
    assign expire    = div_tick && running_q && last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            running_q <= 1'b0;
        end else if (start) begin
            cur_q     <= load_val;
            running_q <= |load_val;
        end else if (div_tick && running_q) begin
            if (last_step) begin
                if (periodic) begin
                    cur_q <= reload_val;
                end else begin
                    cur_q     <= '0;
                    running_q <= 1'b0;
                end
            end else begin
                cur_q <= cur_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/itmr_pending.sv
module itmr_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              expire,
    input  logic              take,
    output logic [PEND_W-1:0] pend_q
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend_q <= '0;
        end else begin
            case ({expire, take})
                2'b10: if (pend_q != PEND_MAX) pend_q <= pend_q + PEND_W'(1);
                2'b01: pend_q <= pend_q - PEND_W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

endmodule

// File: rtl/intc_timer.sv
module intc_timer
    import itmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4,
    parameter int PRE_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector
);

    logic                    sw_en;
    logic [VEC_W-1:0]        spur_vec;
    tbl_entry_t [TBL_N-1:0]  tbl_q;
    logic [DIV_CODE_W-1:0]   div_q;
    logic [CNT_W-1:0]        init_q;
    logic                    start;
    logic                    sw_off;
    logic                    div_tick;
    logic [CNT_W-1:0]        cur_q;
    logic                    running_q;
    logic                    expire;
    logic [PEND_W-1:0]       pend_q;
    logic                    take;
    logic [TBL_N-1:0]        mask_vec;
    logic [REG_W-1:0]        tbl_words [TBL_N];

    itmr_regs #(.CNT_W(CNT_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .sw_en    (sw_en),
        .spur_vec (spur_vec),
        .tbl_q    (tbl_q),
        .div_q    (div_q),
        .init_q   (init_q),
        .start    (start),
        .sw_off   (sw_off)
    );

    itmr_prescale #(.PRE_W(PRE_W)) pre_i (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .restart  (start),
        .div_sel  ({div_q[3], div_q[1:0]}),
        .div_tick (div_tick)
    );

    itmr_count #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load_val   (wr_data[CNT_W-1:0]),
        .reload_val (init_q),
        .periodic   (tbl_q[0].periodic),
        .div_tick   (div_tick),
        .cur_q      (cur_q),
        .running_q  (running_q),
        .expire     (expire)
    );

    itmr_pending #(.PEND_W(PEND_W)) pend_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start || sw_off),
        .expire (expire),
        .take   (take),
        .pend_q (pend_q)
    );

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        assign tbl_words[g] = tbl_word(tbl_q[g]);
        assign mask_vec[g]  = tbl_q[g].masked;
    end

    assign irq_req    = sw_en && !mask_vec[0] && (pend_q != '0);
    assign irq_vector = tbl_q[0].vec;
    assign take       = irq_ack && irq_req;

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_SPUR: rd_data = REG_W'({sw_en, spur_vec});
            SEL_INIT: rd_data = REG_W'(init_q);
            SEL_CUR:  rd_data = REG_W'(cur_q);
            SEL_DIV:  rd_data = REG_W'(div_q);
            default: begin
                if (rd_sel[3] && (int'(rd_sel[2:0]) < TBL_N)) begin
                    rd_data = tbl_words[rd_sel[2:0]];
                end
            end
        endcase
    end

endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
    import itmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic              spur_en_wr,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              sw_en,
    input logic [TBL_N-1:0]  tbl_mask,
    input logic [CNT_W-1:0]  init_q,
    input logic [CNT_W-1:0]  cur_q,
    input logic              running_q,
    input logic              periodic,
    input logic              expire,
    input logic              start,
    input logic              sw_off,
    input logic [PEND_W-1:0] pend_q
);

    // R3
    zero_start_cur_chk: assert property (@(posedge clk) disable iff (rst)
        (init_q == '0) |-> (cur_q == '0));

    // R4
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !periodic) |=> (!running_q && (cur_q == '0)));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic) |=> (cur_q == $past(init_q)));

    // R6
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == SEL_INIT)) |=> !irq_req);

    // R8
    ack_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && !expire && !start && !sw_off)
        |=> (pend_q == $past(pend_q) - PEND_W'(1)));

    // R9
    sw_off_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == SEL_SPUR) && !spur_en_wr) |=> ((&tbl_mask) && !irq_req));

    // R10
    disabled_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!sw_en && wr_en && wr_sel[3] && (int'(wr_sel[2:0]) < TBL_N))
        |=> tbl_mask[$past(wr_sel[2:0])]);

endmodule

bind intc_timer itmr_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .spur_en_wr (wr_data[itmr_pkg::SPUR_EN_BIT]),
    .irq_req    (irq_req),
    .irq_ack    (irq_ack),
    .sw_en      (sw_en),
    .tbl_mask   (mask_vec),
    .init_q     (init_q),
    .cur_q      (cur_q),
    .running_q  (running_q),
    .periodic   (tbl_q[0].periodic),
    .expire     (expire),
    .start      (start),
    .sw_off     (sw_off),
    .pend_q     (pend_q)
);

// File: tb/intc_timer_tb_top.sv
`timescale 1ns/1ps
module intc_timer_tb_top;
    import itmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        irq_ack = 1'b0;
    logic [3:0]  wr_sel = 4'h0;
    logic [3:0]  rd_sel = 4'h2;
    logic [31:0] wr_data = 32'h0;
    wire  [31:0] rd_data;
    wire         irq_req;
    wire  [7:0]  irq_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intc_timer dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // reference model state
    bit          m_sw;
    logic [7:0]  m_spv;
    bit          m_mask [6];
    logic [7:0]  m_vec [6];
    bit          m_per;
    logic [3:0]  m_div;
    logic [31:0] m_init;
    logic [31:0] m_cur;
    bit          m_run;
    int          m_phase;
    int          m_pend;

    function automatic int ratio(input logic [3:0] c);
        int e;
        e = ({c[3], c[1:0]} + 1) % 8;
        return 1 << e;
    endfunction

    function automatic bit m_req();
        return m_sw && !m_mask[0] && (m_pend != 0);
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        int k;
        case (a)
            4'h0: return {23'b0, m_sw, m_spv};
            4'h1: return m_init;
            4'h2: return m_cur;
            4'h3: return {28'b0, m_div};
            default: begin
                if (a >= 4'h8 && a < 4'hE) begin
                    k = int'(a) - 8;
                    return {14'b0, (k == 0) ? m_per : 1'b0, m_mask[k], 8'b0, m_vec[k]};
                end
                return 32'h0;
            end
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        if (a == 4'h0 || (a >= 4'h8 && a < 4'hE)) return "R9";
        if (a == 4'h1) return "R2";
        if (a == 4'h2) return "R3";
        if (a == 4'h3) return "R1";
        return "R12";
    endfunction

    always @(posedge clk) begin
        bit st, off, dt, ex, tk;
        int k;
        if (rst) begin
            m_sw = 0; m_spv = 8'hFF; m_per = 0; m_div = 0; m_init = 0;
            m_cur = 0; m_run = 0; m_phase = 0; m_pend = 0;
            for (int i = 0; i < 6; i++) begin m_mask[i] = 1; m_vec[i] = 0; end
        end else begin
            st  = wr_en && wr_sel == 4'h1;
            off = wr_en && wr_sel == 4'h0 && !wr_data[8];
            dt  = tick_en && !st && (m_phase >= ratio(m_div) - 1);
            ex  = dt && m_run && (m_cur == 1);
            tk  = irq_ack && m_req();
            if (st) begin
                m_cur = wr_data; m_run = (wr_data != 0); m_phase = 0;
            end else begin
                if (tick_en) m_phase = dt ? 0 : m_phase + 1;
                if (dt && m_run) begin
                    if (m_cur == 1) begin
                        if (m_per) m_cur = m_init;
                        else begin m_cur = 0; m_run = 0; end
                    end else m_cur = m_cur - 1;
                end
            end
            if (st || off) m_pend = 0;
            else if (ex && !tk) m_pend = (m_pend == 15) ? 15 : m_pend + 1;
            else if (tk && !ex) m_pend = m_pend - 1;
            if (wr_en) begin
                case (wr_sel)
                    4'h0: begin
                        m_sw = wr_data[8]; m_spv = wr_data[7:0];
                        if (!wr_data[8]) for (int i = 0; i < 6; i++) m_mask[i] = 1;
                    end
                    4'h1: m_init = wr_data;
                    4'h3: m_div = wr_data[3:0];
                    default: begin
                        if (wr_sel >= 4'h8 && wr_sel < 4'hE) begin
                            k = int'(wr_sel) - 8;
                            m_vec[k]  = wr_data[7:0];
                            m_mask[k] = wr_data[16] | !m_sw;
                            if (k == 0) m_per = wr_data[17];
                        end
                    end
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: edge, then compare outputs half a period later
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #0.5;
        chk("R7", {31'b0, irq_req}, {31'b0, m_req()});
        if (m_req()) chk("R7", {24'b0, irq_vector}, {24'b0, m_vec[0]});
        chk(tag_for(rd_sel), rd_data, m_read(rd_sel));
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_at(input logic [3:0] s, output logic [31:0] v);
        rd_sel = s;
        #0.2;
        v = rd_data;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        rd_at(4'h0, v); chk("R11", v, 32'h0000_00FF);
        rd_at(4'h1, v); chk("R11", v, 32'h0);
        rd_at(4'h2, v); chk("R11", v, 32'h0);
        rd_at(4'h3, v); chk("R11", v, 32'h0);
        for (int i = 8; i < 14; i++) begin
            rd_at(4'(i), v); chk("R11", v, 32'h0001_0000);
        end
        chk("R11", {31'b0, irq_req}, 32'h0);
        rd_at(4'h5, v); chk("R12", v, 32'h0);
        rst = 1'b0;
        rd_sel = 4'h2;

        // R4 one-shot at divide-by-1
        wr(4'h0, 32'h1FF);
        wr(4'h8, 32'h0000_0040);
        wr(4'h3, 32'hB);
        tick_en = 1'b1;
        wr(4'h1, 32'd3);
        chk("R2", rd_data, 32'd3);
        tick(); tick();
        chk("R1", rd_data, 32'd1);
        chk("R4", {31'b0, irq_req}, 32'h0);
        tick();
        chk("R4", rd_data, 32'd0);
        chk("R7", {31'b0, irq_req}, 32'h1);
        chk("R7", {24'b0, irq_vector}, 32'h40);
        repeat (3) tick();
        chk("R4", rd_data, 32'd0);

        // R8 acknowledge consumes the single expiry
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R8", {31'b0, irq_req}, 32'h0);

        // R1 divide-by-2 with code 0
        wr(4'h3, 32'h0);
        wr(4'h1, 32'd2);
        repeat (3) tick();
        chk("R1", rd_data, 32'd1);
        chk("R1", {31'b0, irq_req}, 32'h0);
        tick();
        chk("R1", rd_data, 32'd0);
        chk("R1", {31'b0, irq_req}, 32'h1);

        // R5 periodic reload, R6 restart clears pending
        wr(4'h3, 32'hB);
        wr(4'h8, 32'h0002_0040);
        wr(4'h1, 32'd2);
        chk("R6", {31'b0, irq_req}, 32'h0);
        tick(); tick();
        chk("R5", rd_data, 32'd2);
        chk("R5", {31'b0, irq_req}, 32'h1);
        tick(); tick();
        chk("R5", rd_data, 32'd2);

        // R7 mask hides outstanding expiries
        wr(4'h8, 32'h0003_0040);
        chk("R7", {31'b0, irq_req}, 32'h0);
        wr(4'h8, 32'h0002_0040);
        chk("R7", {31'b0, irq_req}, 32'h1);

        // R9 software disable, R10 masked store while disabled
        tick_en = 1'b0;
        wr(4'h0, 32'h0FF);
        for (int i = 8; i < 14; i++) begin
            rd_at(4'(i), v); chk("R9", {31'b0, v[16]}, 32'h1);
        end
        chk("R9", {31'b0, irq_req}, 32'h0);
        rd_sel = 4'hA;
        wr(4'hA, 32'h0002_0055);
        chk("R10", rd_data, 32'h0001_0055);
        wr(4'h0, 32'h1FF);
        wr(4'h8, 32'h0002_0040);
        chk("R9", {31'b0, irq_req}, 32'h0);

        // R2/R3 zero start count and ignored write to current count
        rd_sel = 4'h2;
        wr(4'h1, 32'h0);
        tick_en = 1'b1;
        repeat (4) tick();
        chk("R2", {31'b0, irq_req}, 32'h0);
        chk("R3", rd_data, 32'h0);
        wr(4'h2, 32'h1234);
        chk("R3", rd_data, 32'h0);
        rd_sel = 4'hF;
        wr(4'hF, 32'hFFFF_FFFF);
        chk("R12", rd_data, 32'h0);
        rd_sel = 4'h2;

        // R8 saturation at 15
        wr(4'h1, 32'd1);
        repeat (20) tick();
        tick_en = 1'b0;
        irq_ack = 1'b1;
        repeat (14) tick();
        chk("R8", {31'b0, irq_req}, 32'h1);
        tick();
        irq_ack = 1'b0;
        chk("R8", {31'b0, irq_req}, 32'h0);

        // constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int op;
            tick_en = ($urandom % 4) != 0;
            irq_ack = ($urandom % 2) != 0;
            rd_sel  = 4'($urandom % 16);
            op = $urandom % 16;
            wr_en = 1'b1;
            case (op)
                0: begin wr_sel = 4'h1; wr_data = $urandom % 12; end
                1: begin wr_sel = 4'h3; wr_data = $urandom % 16; end
                2: begin
                    wr_sel = 4'h8;
                    wr_data = {14'b0, 1'($urandom % 2), 1'(($urandom % 4) == 0), 8'b0, 8'($urandom)};
                end
                3: begin wr_sel = 4'h0; wr_data = {23'b0, 1'(($urandom % 5) != 0), 8'($urandom)}; end
                4: begin wr_sel = 4'(9 + $urandom % 5); wr_data = $urandom; end
                5: begin wr_sel = 4'h2; wr_data = $urandom; end
                6: begin wr_sel = 4'(4 + $urandom % 4); wr_data = $urandom; end
                default: wr_en = 1'b0;
            endcase
            tick();
            wr_en = 1'b0;
        end
        irq_ack = 1'b0;
        tick_en = 1'b0;
        finish_run();
    end

endmodule